// File: doc/BRIEF.md
# Step Pacing Controller

This block sets the length of each execution step of a datapath that is rebuilt from a new configuration context on every step. It runs on a fast base clock. The program counter and the distributed result registers advance only when the block raises its step-enable pulse, so a step is a whole number of base-clock cycles long. Each configuration context carries a small wait field, so software sets the cycle budget step by step. A context with a shallow datapath gets a short step. A context with long chained operators gets enough time for its critical path to settle before the results are captured.

A step starts on the first live cycle after reset or after the previous pulse. In that cycle the block samples the wait field W and then counts live cycles. On the (W+1)-th live cycle it pulses `step_en_o` for one cycle. The context source treats that pulse as its acceptance of the current context. It may present the next context from the following cycle on. Holding `ctx_valid_i` low tells the block that no context is ready, and `run_i` low pauses the array. In both cases the count is frozen, not lost. `gclk_en_o` tells the clock-gating logic when the pacing clock is live.

Top module: `step_pace_ctrl`

## Requirements
- R1: With wait field W (unsigned, `wait_i` bits [3:0]) sampled in the first live cycle of a step, `step_en_o` is high in the (W+1)-th live cycle of that step and low in the W earlier live cycles. A live cycle is one with `run_i`=1, `ctx_valid_i`=1, reset released and at least one clock edge since release.
- R2: W=0 gives a one-cycle step: `step_en_o` rises in the first live cycle, and consecutive W=0 steps pulse on every live cycle.
- R3: After a pulse, the next live cycle starts a new step and samples `wait_i` afresh.
- R4: In a cycle with `run_i`=0 or `ctx_valid_i`=0, `step_en_o` is low and the step's progress is held unchanged.
- R5: Changes of `wait_i` after the first live cycle of a step have no effect on when that step's pulse occurs.
- R6: While `rst_n` is low, and in the first cycle after it rises, both outputs are low. Reset abandons any step in progress.
- R7: `gclk_en_o` is high exactly in live cycles, and `step_en_o` is never high without it.
- R8: The largest wait field, 15, gives a step of 16 live cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Global run; low pauses the step count |
| ctx_valid_i | input | 1 | Active configuration context is valid |
| wait_i | input | 4 | Wait field of the active context |
| step_en_o | output | 1 | One-cycle enable for program counter and registers |
| gclk_en_o | output | 1 | Pacing clock is live this cycle |

## Verification
The bench runs back-to-back W=0 steps. A design that reloads a step only one cycle late would drop every other pulse. It pauses with both `run_i` and `ctx_valid_i` in the middle of long steps. A design that restarts or keeps counting across a pause would pulse early or late. The bench also changes `wait_i` in the middle of a step, where a design that reads the field live would shift the pulse. It checks the largest wait field, where an off-by-one in the count or wrap at the top of the field would show. It checks the dead cycle after reset release, where a design would pulse on a stale count.

// File: rtl/step_pace_pkg.sv
package step_pace_pkg;
  localparam int unsigned DEF_WAIT_W = 4;
  localparam int unsigned MAX_STEP_CYC = 1 << DEF_WAIT_W;
endpackage

// File: rtl/step_pace_live.sv
module step_pace_live (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic ctx_valid_i,
  output logic live_o
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign live_o = armed_q && run_i && ctx_valid_i;
endmodule

// File: rtl/step_pace_count.sv
module step_pace_count #(
  parameter int unsigned WAIT_W = step_pace_pkg::DEF_WAIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              fire_o
);
  localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

  logic [WAIT_W-1:0] left_q;
  logic              busy_q;

  assign fire_o = live_i && (busy_q ? (left_q == '0) : (wait_i == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (live_i) begin
      if (fire_o) begin
        busy_q <= 1'b0;
      end else if (!busy_q) begin
        left_q <= wait_i - ONE;
        busy_q <= 1'b1;
      end else begin
        left_q <= left_q - ONE;
      end
    end
  end
endmodule

// File: rtl/step_pace_ctrl.sv
module step_pace_ctrl #(
  parameter int unsigned WAIT_W = step_pace_pkg::DEF_WAIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              ctx_valid_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              step_en_o,
  output logic              gclk_en_o
);
  logic live;

  step_pace_live u_live (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_i),
    .ctx_valid_i (ctx_valid_i),
    .live_o      (live)
  );

  step_pace_count #(.WAIT_W(WAIT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .live_i (live),
    .wait_i (wait_i),
    .fire_o (step_en_o)
  );

  assign gclk_en_o = live;
endmodule

// File: rtl/step_pace_ctrl_chk.sv
module step_pace_ctrl_chk #(
  parameter int unsigned WAIT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_i,
  input logic              ctx_valid_i,
  input logic [WAIT_W-1:0] wait_i,
  input logic              step_en_o,
  input logic              gclk_en_o
);
  logic            c_fresh;
  logic [WAIT_W:0] c_tgt;
  logic [WAIT_W:0] c_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_fresh <= 1'b1;
      c_tgt   <= '0;
      c_done  <= '0;
    end else if (gclk_en_o) begin
      if (step_en_o) begin
        c_fresh <= 1'b1;
      end else if (c_fresh) begin
        c_fresh <= 1'b0;
        c_tgt   <= {1'b0, wait_i};
        c_done  <= (WAIT_W+1)'(1);
      end else begin
        c_done  <= c_done + (WAIT_W+1)'(1);
      end
    end
  end

  p_quiet_paused_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_en_o |-> (run_i && ctx_valid_i));

  p_en_needs_gclk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_en_o |-> gclk_en_o);

  p_reset_quiet_r6: assert property (@(posedge clk)
    !rst_n |-> (!step_en_o && !gclk_en_o));

  p_zero_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gclk_en_o && c_fresh) |-> (step_en_o == (wait_i == '0)));

  p_step_length_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (gclk_en_o && !c_fresh) |-> (step_en_o == (c_done == c_tgt)));

  p_held_pause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !gclk_en_o |=> $stable(c_done));
endmodule

bind step_pace_ctrl step_pace_ctrl_chk #(.WAIT_W(WAIT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_i       (run_i),
  .ctx_valid_i (ctx_valid_i),
  .wait_i      (wait_i),
  .step_en_o   (step_en_o),
  .gclk_en_o   (gclk_en_o)
);

// File: tb/sim_step_pace_ctrl.sv
`timescale 1ns/1ps
module sim_step_pace_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_i = 1'b0;
  logic       ctx_valid_i = 1'b0;
  logic [3:0] wait_i = 4'd0;
  logic       step_en_o;
  logic       gclk_en_o;

  int compared = 0;
  int mismatched = 0;
  int cyc_n = 0;
  bit done = 1'b0;

  // reference model state
  bit m_armed = 1'b0;
  bit m_in_step = 1'b0;
  int m_target = 0;
  int m_elapsed = 0;

  always #4 clk = ~clk;

  step_pace_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .ctx_valid_i(ctx_valid_i),
    .wait_i(wait_i), .step_en_o(step_en_o), .gclk_en_o(gclk_en_o)
  );

  task automatic check(input bit act, input bit exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", what, cyc_n, act, exp);
    end
  endtask

  // one clock: drive inputs after negedge, compare, then advance the model at posedge
  task automatic tick(input bit r, input bit rn, input bit v, input int w, input string tag);
    bit live;
    bit exp_en;
    @(negedge clk);
    rst_n = r; run_i = rn; ctx_valid_i = v; wait_i = 4'(w);
    #1;
    live = r && m_armed && rn && v;
    exp_en = 1'b0;
    if (live) begin
      if (!m_in_step) begin
        m_target = w;
        m_elapsed = 0;
      end
      exp_en = (m_elapsed == m_target);
    end
    check(step_en_o, exp_en, {tag, " step_en"});
    check(gclk_en_o, live, {"R7 ", tag, " gclk_en"});
    @(posedge clk);
    cyc_n++;
    if (!r) begin
      m_armed = 1'b0; m_in_step = 1'b0; m_elapsed = 0;
    end else begin
      m_armed = 1'b1;
      if (live) begin
        if (exp_en) m_in_step = 1'b0;
        else begin m_in_step = 1'b1; m_elapsed++; end
      end
    end
  endtask

  initial begin
    // R6: reset holds outputs low even with live inputs
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, 1'b1, 0, "R6 reset");
    // R6: first cycle after release is dead
    tick(1'b1, 1'b1, 1'b1, 0, "R6 release");
    // R2: back-to-back single-cycle steps
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b1, 1'b1, 0, "R2 zero");
    // R1/R3: mixed wait values, reloaded after each pulse
    for (int s = 1; s < 6; s++)
      for (int i = 0; i <= s; i++) tick(1'b1, 1'b1, 1'b1, s, "R1 R3 step");
    // R8: largest field
    for (int i = 0; i < 18; i++) tick(1'b1, 1'b1, 1'b1, 15, "R8 max");
    // R5: field changes inside a step
    tick(1'b1, 1'b1, 1'b1, 6, "R5 start");
    for (int i = 0; i < 8; i++) tick(1'b1, 1'b1, 1'b1, i % 2, "R5 change");
    // R4: pauses via run and via valid mid-step
    tick(1'b1, 1'b1, 1'b1, 4, "R4 start");
    tick(1'b1, 1'b1, 1'b1, 4, "R4 count");
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, 1'b1, 0, "R4 run low");
    tick(1'b1, 1'b1, 1'b1, 0, "R4 resume");
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 1'b0, 0, "R4 valid low");
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b1, 1'b1, 2, "R4 finish");
    // R6: reset in the middle of a long step
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b1, 1'b1, 12, "R6 pre");
    tick(1'b0, 1'b1, 1'b1, 12, "R6 mid reset");
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b1, 1'b1, 1, "R6 after");
    // mixed pseudo-random stimulus
    for (int i = 0; i < 600; i++) begin
      int rv;
      rv = (i * 37 + 11) % 101;
      tick(1'b1, rv % 7 != 0, rv % 5 != 0, (i * 13 + rv) % 16, "R1 R4 R5 mix");
    end
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule